// File: doc/BRIEF.md
# Distributed Priority Bus Arbiter

This block is the arbitration engine that sits inside every unit on a shared bus that has no central controller. A unit that wants the bus takes part in a contest that runs on its own set of wired lines: eight active-low, wired-AND contention lines, a strobe that paces the contest, and a seize line that marks a contest start. The contest runs alongside ordinary transfers on the rest of the bus. It has four paced steps. In the first step each contender pulls the contention line whose index equals its priority level. The next three steps break ties among the survivors using the unit's 8-bit address, which is cut into three digits and sent top digit first. In every step a contender that sees an active line above its own drops out and stays silent until the contest ends.

The unit asks to contend by raising `req` with a level on `req_prio`. After the fourth strobe edge it gets a one-clock `win` or `lose` pulse. The enables `pr_pull` and `bs_pull` drive external open-collector pull-downs. The bus levels come back on `pr_n` and `bs_n`, and the strobe on `brs_n` must be synchronous to `clk`. All pins are plain control and status signals. There is no streaming interface and no back-pressure.

Top module: `prio_bus_arbiter`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `pr_pull`, `bs_pull`, `win` and `lose` are all zero.
- R2: An idle unit that sees `req` high at a clock edge joins a contest. From the next cycle it drives `pr_pull` one-hot at bit index `req_prio` and holds `bs_pull` high.
- R3: The contest advances on each rising edge of `brs_n`, and the contention lines are sampled at that edge. After the first edge `bs_pull` is released.
- R4: If any contention line above the unit's current code is low at a sampled edge, the unit clears `pr_pull` from the next cycle and keeps it zero until the contest ends.
- R5: After edges 1, 2 and 3 a surviving unit sends, in turn, `unit_addr[7:6]` (line 0 to 3), `unit_addr[5:3]` and `unit_addr[2:0]`. The digit value n is sent by driving line n.
- R6: At equal priority the larger address wins. A higher priority always wins, whatever the addresses.
- R7: After the fourth edge a unit that never dropped out pulses `win` for exactly one cycle, and a unit that dropped out pulses `lose` for exactly one cycle. In both cases all pulls are zero afterwards.
- R8: A unit without a request drives nothing. If it sees `bs_n` low while idle, it follows the four edges silently and ignores `req` until the contest ends.
- R9: Changes on `req`, `req_prio` or `unit_addr` during a contest have no effect on a participant's pulls or on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request to contend for the bus |
| req_prio | input | 3 | Priority level, 7 is the highest |
| unit_addr | input | 8 | This unit's address, used for the tie-break |
| brs_n | input | 1 | Contest strobe level; a rising edge ends a step |
| bs_n | input | 1 | Seize line level, low marks a contest start |
| pr_n | input | 8 | Contention line levels, active low |
| pr_pull | output | 8 | Pull-down enables for the contention lines |
| bs_pull | output | 1 | Pull-down enable for the seize line |
| win | output | 1 | One-clock pulse: this unit is the new master |
| lose | output | 1 | One-clock pulse: this unit was beaten |

## Verification
A wrong step counter or wrong digit selection shows on `pr_pull` in the cycle after the strobe edge that should have moved it: the wrong line is driven, or a line is driven past the fourth edge. A lost drop-out flag shows as a line still being pulled in the very next cycle after a higher line was seen. It also shows as a `win` where `lose` belongs, four edges at most after the fault. An observer that loses track of the contest becomes visible as soon as a late request makes it drive a line.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int unsigned PR_LINES = 8;
  localparam int unsigned CODE_W   = $clog2(PR_LINES);
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned ROUNDS   = 4;
  localparam int unsigned RND_W    = $clog2(ROUNDS);

  typedef enum logic [1:0] {
    ARB_IDLE  = 2'd0,
    ARB_RUN   = 2'd1,
    ARB_WATCH = 2'd2
  } arb_state_e;
endpackage

// File: rtl/arb_code_sel.sv
module arb_code_sel
  import arb_pkg::*;
(
  input  logic [RND_W-1:0]  round,
  input  logic [CODE_W-1:0] prio,
  input  logic [ADDR_W-1:0] addr,
  output logic [CODE_W-1:0] code
);
  // step 0 carries the priority; steps 1..3 carry address digits, top first
  always_comb begin
    case (round)
      2'd0:    code = prio;
      2'd1:    code = {1'b0, addr[7:6]};
      2'd2:    code = addr[5:3];
      default: code = addr[2:0];
    endcase
  end
endmodule

// File: rtl/arb_line_cmp.sv
module arb_line_cmp
  import arb_pkg::*;
(
  input  logic [CODE_W-1:0]   code,
  input  logic [PR_LINES-1:0] lines_act,
  output logic [PR_LINES-1:0] onehot,
  output logic                above
);
  logic [PR_LINES-1:0] hi_mask;

  for (genvar i = 0; i < PR_LINES; i++) begin : g_line
    assign onehot[i]  = (code == CODE_W'(i));
    assign hi_mask[i] = (CODE_W'(i) > code);
  end

  assign above = |(lines_act & hi_mask);
endmodule

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             bs_seen,
  input  logic             brs_edge,
  input  logic             above,
  output arb_state_e       state,
  output logic [RND_W-1:0] round,
  output logic             alive,
  output logic             win,
  output logic             lose
);
  localparam logic [RND_W-1:0] LAST = RND_W'(ROUNDS - 1);

  logic survives;
  assign survives = alive && !above;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ARB_IDLE;
      round <= '0;
      alive <= 1'b0;
      win   <= 1'b0;
      lose  <= 1'b0;
    end else begin
      win  <= 1'b0;
      lose <= 1'b0;
      case (state)
        ARB_IDLE: begin
          round <= '0;
          if (req) begin
            state <= ARB_RUN;
            alive <= 1'b1;
          end else if (bs_seen) begin
            state <= ARB_WATCH;
          end
        end
        ARB_RUN: begin
          if (brs_edge) begin
            if (round == LAST) begin
              state <= ARB_IDLE;
              round <= '0;
              alive <= 1'b0;
              win   <= survives;
              lose  <= !survives;
            end else begin
              round <= round + 1'b1;
              alive <= survives;
            end
          end
        end
        ARB_WATCH: begin
          if (brs_edge) begin
            if (round == LAST) begin
              state <= ARB_IDLE;
              round <= '0;
            end else begin
              round <= round + 1'b1;
            end
          end
        end
        default: state <= ARB_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter
  import arb_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req,
  input  logic [CODE_W-1:0]   req_prio,
  input  logic [ADDR_W-1:0]   unit_addr,
  input  logic                brs_n,
  input  logic                bs_n,
  input  logic [PR_LINES-1:0] pr_n,
  output logic [PR_LINES-1:0] pr_pull,
  output logic                bs_pull,
  output logic                win,
  output logic                lose
);
  logic                brs_q;
  logic                brs_edge;
  arb_state_e          state;
  logic [RND_W-1:0]    round;
  logic                alive;
  logic [CODE_W-1:0]   code;
  logic [CODE_W-1:0]   prio_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [PR_LINES-1:0] onehot;
  logic                above;
  logic                driving;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) brs_q <= 1'b1;
    else        brs_q <= brs_n;
  end
  assign brs_edge = brs_n && !brs_q;

  // capture the contest identity at join so later input changes are ignored
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
      addr_q <= '0;
    end else if (state == ARB_IDLE && req) begin
      prio_q <= req_prio;
      addr_q <= unit_addr;
    end
  end

  arb_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .bs_seen  (!bs_n),
    .brs_edge (brs_edge),
    .above    (above),
    .state    (state),
    .round    (round),
    .alive    (alive),
    .win      (win),
    .lose     (lose)
  );

  arb_code_sel u_sel (
    .round (round),
    .prio  (prio_q),
    .addr  (addr_q),
    .code  (code)
  );

  arb_line_cmp u_cmp (
    .code      (code),
    .lines_act (~pr_n),
    .onehot    (onehot),
    .above     (above)
  );

  assign driving = (state == ARB_RUN) && alive;
  assign pr_pull = driving ? onehot : '0;
  assign bs_pull = driving && (round == '0);
endmodule

// File: rtl/prio_bus_arbiter_chk.sv
module prio_bus_arbiter_chk
  import arb_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                req,
  input logic [PR_LINES-1:0] pr_pull,
  input logic                bs_pull,
  input logic                win,
  input logic                lose
);
  a_r2_join_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|pr_pull) |-> $past(req));

  a_r4_single_line: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pr_pull));

  a_r3_seize_with_line: assert property (@(posedge clk) disable iff (!rst_n)
    bs_pull |-> (|pr_pull));

  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(win && lose));

  a_r7_win_from_driver: assert property (@(posedge clk) disable iff (!rst_n)
    win |-> $past(|pr_pull));

  a_r7_win_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    win |=> !win);

  a_r7_lose_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    lose |=> !lose);
endmodule

bind prio_bus_arbiter prio_bus_arbiter_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .req     (req),
  .pr_pull (pr_pull),
  .bs_pull (bs_pull),
  .win     (win),
  .lose    (lose)
);

// File: tb/test_prio_bus_arbiter.sv
module test_prio_bus_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic [2:0] req_prio = '0;
  logic [7:0] unit_addr = '0;
  logic       brs_n = 1'b1;
  logic [7:0] comp_lines = '0;
  logic       comp_bs = 1'b0;
  logic [7:0] pr_pull;
  logic       bs_pull, win, lose;
  logic [7:0] pr_n;
  logic       bs_n;
  int         tests = 0;
  int         fails = 0;

  always #10 clk = ~clk;

  assign pr_n = ~(pr_pull | comp_lines);
  assign bs_n = ~(bs_pull | comp_bs);

  prio_bus_arbiter i_prio_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .req(req), .req_prio(req_prio),
    .unit_addr(unit_addr), .brs_n(brs_n), .bs_n(bs_n), .pr_n(pr_n),
    .pr_pull(pr_pull), .bs_pull(bs_pull), .win(win), .lose(lose)
  );

  typedef struct packed {
    logic       dreq; logic [2:0] dp; logic [7:0] da;
    logic       e1;   logic [2:0] p1; logic [7:0] a1;
    logic       e2;   logic [2:0] p2; logic [7:0] a2;
    logic [1:0] expr;  // 0 none, 1 win, 2 lose
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{1'b1, 3'd5, 8'h10, 1'b1, 3'd3, 8'h20, 1'b0, 3'd0, 8'h00, 2'd1},
    '{1'b1, 3'd2, 8'h40, 1'b1, 3'd6, 8'h01, 1'b0, 3'd0, 8'h00, 2'd2},
    '{1'b1, 3'd4, 8'h9A, 1'b1, 3'd4, 8'h5A, 1'b0, 3'd0, 8'h00, 2'd1},
    '{1'b1, 3'd4, 8'h5A, 1'b1, 3'd4, 8'h9A, 1'b0, 3'd0, 8'h00, 2'd2},
    '{1'b1, 3'd7, 8'h4B, 1'b1, 3'd7, 8'h4D, 1'b1, 3'd7, 8'h49, 2'd2},
    '{1'b1, 3'd7, 8'h4D, 1'b1, 3'd7, 8'h4B, 1'b1, 3'd7, 8'h49, 2'd1},
    '{1'b1, 3'd1, 8'h68, 1'b1, 3'd1, 8'h58, 1'b1, 3'd0, 8'hFF, 2'd1},
    '{1'b0, 3'd0, 8'h00, 1'b1, 3'd3, 8'h11, 1'b1, 3'd2, 8'h22, 2'd0},
    '{1'b1, 3'd0, 8'h00, 1'b0, 3'd0, 8'h00, 1'b0, 3'd0, 8'h00, 2'd1}
  };

  function automatic logic [2:0] code_of(int r, logic [2:0] p, logic [7:0] a);
    case (r)
      0:       return p;
      1:       return {1'b0, a[7:6]};
      2:       return a[5:3];
      default: return a[2:0];
    endcase
  endfunction

  function automatic logic beaten(logic [7:0] lines, logic [2:0] c);
    return |(lines >> (int'(c) + 1));
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_contest(vec_t v);
    logic ad = v.dreq, a1 = v.e1, a2 = v.e2;
    logic [7:0] dl;
    @(negedge clk);
    req = v.dreq; req_prio = v.dp; unit_addr = v.da;
    comp_bs = v.e1 | v.e2;
    @(negedge clk);
    req = 1'b0;
    for (int r = 0; r < 4; r++) begin
      if (r == 2) begin req = 1'b1; req_prio = 3'd7; unit_addr = 8'hFF; end
      if (r == 3) req = 1'b0;
      brs_n = 1'b0;
      comp_lines = (a1 ? (8'd1 << code_of(r, v.p1, v.a1)) : 8'd0)
                 | (a2 ? (8'd1 << code_of(r, v.p2, v.a2)) : 8'd0);
      comp_bs = (r == 0) && (a1 | a2);
      @(negedge clk); @(negedge clk);
      dl = ad ? (8'd1 << code_of(r, v.dp, v.da)) : 8'd0;
      // R2 join line, R5 digit lines, R4 silence, R8 observer silence
      chk(r == 0 ? "R2" : (ad ? "R5" : (v.dreq ? "R4" : "R8")), pr_pull, dl);
      chk("R3", bs_pull, ad && r == 0);
      brs_n = 1'b1;
      @(negedge clk);
      begin
        logic [7:0] ln = comp_lines | dl;
        if (ad && beaten(ln, code_of(r, v.dp, v.da))) ad = 1'b0;
        if (a1 && beaten(ln, code_of(r, v.p1, v.a1))) a1 = 1'b0;
        if (a2 && beaten(ln, code_of(r, v.p2, v.a2))) a2 = 1'b0;
      end
    end
    comp_lines = '0; comp_bs = 1'b0;
    chk("R6", {win, lose}, {v.expr == 2'd1, v.expr == 2'd2});
    chk("R7", {win, lose}, {v.dreq && ad, v.dreq && !ad});
    chk("R9", win, v.expr == 2'd1);
    @(negedge clk);
    chk("R7", {win, lose, bs_pull}, 3'b000);
    chk("R7", pr_pull, 8'h00);
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1", {pr_pull, bs_pull, win, lose}, 11'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {pr_pull, bs_pull, win, lose}, 11'h0);

    for (int i = 0; i < 9; i++) run_contest(VECS[i]);

    // mid-contest reset clears all drive (R1)
    @(negedge clk);
    req = 1'b1; req_prio = 3'd6; unit_addr = 8'h33;
    @(negedge clk);
    req = 1'b0;
    chk("R2", pr_pull, 8'h40);
    chk("R2", bs_pull, 1'b1);
    rst_n = 1'b0;
    #1;
    chk("R1", {pr_pull, bs_pull, win, lose}, 11'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {pr_pull, bs_pull, win, lose}, 11'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule